// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation structure held in memory. It handles only the slow path, the translations that a lookaside cache has already missed. A request is accepted on a valid/ready handshake. The walker then reads one top-level entry. If that entry points at an allocated second-level table, the walker reads one entry from that table. It reports the result with a single-cycle completion pulse.

The address splits into three fields. The upper ten bits select a top-level entry, the middle ten bits select a second-level entry, and the low twelve bits pass through unchanged as the page offset. Memory is reached through a port that has one outstanding read at a time: a one-cycle request strobe with an address, then a response strobe with data some cycles later. The physical base of the top-level table comes in on an input port.

The controller has six states. `ST_IDLE` waits for a request. `ST_READ_DIR` issues the top-level read. `ST_WAIT_DIR` waits for that data. `ST_READ_PTE` issues the second-level read. `ST_WAIT_PTE` waits for that data. `ST_DONE` pulses completion. The transitions are as follows:
- accept: `ST_IDLE` to `ST_READ_DIR` when a request is valid.
- issue: `ST_READ_DIR` to `ST_WAIT_DIR`, and `ST_READ_PTE` to `ST_WAIT_PTE`, always after one cycle.
- descend: `ST_WAIT_DIR` to `ST_READ_PTE` when a valid top-level entry returns.
- early fault: `ST_WAIT_DIR` to `ST_DONE` when an invalid top-level entry returns.
- finish: `ST_WAIT_PTE` to `ST_DONE` when the second-level entry returns.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: The virtual address is split into a top-level index in bits 31:22, a second-level index in bits 21:12 and an offset in bits 11:0.
- R2: The first memory read of a walk goes to `dir_base_i` with its low 12 bits cleared, plus four times the top-level index.
- R3: The second-level read is issued only after the top-level response has arrived. Its address is the top-level entry's bits 31:12 followed by 12 zero bits, plus four times the second-level index.
- R4: A top-level entry with bit 0 clear ends the walk with `fault_o` high, after exactly one memory read. The entry's other bits are ignored.
- R5: A second-level entry with bit 0 clear ends the walk with `fault_o` high, after two memory reads.
- R6: On success, `pa_o` equals the second-level entry's bits 31:12 followed by the 12-bit offset, and `fault_o` is low. Bits 11:1 of either entry have no effect.
- R7: `done_o` is high for exactly one cycle per walk. With it, `fault_va_o` equals the request address on a fault and zero on success, and `pa_o` is zero on a fault.
- R8: `req_ready_o` is high only while idle. A request presented while busy is ignored: it does not change the result in progress and starts no walk afterwards.
- R9: After reset, `req_ready_o` is high and both `done_o` and `mem_req_o` are low.
- R10: `mem_req_o` is a single-cycle strobe. No new read is issued while a response is outstanding, and the walk works for any response latency of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base_i | input | 32 | Physical base of the top-level table (low 12 bits ignored) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 32 | Virtual address to translate |
| mem_req_o | output | 1 | One-cycle memory read strobe |
| mem_addr_o | output | 32 | Memory read address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | 32 | Memory read data (one table entry) |
| done_o | output | 1 | One-cycle walk completion pulse |
| fault_o | output | 1 | Walk ended in a page fault (valid with done_o) |
| pa_o | output | 32 | Translated physical address (valid with done_o) |
| fault_va_o | output | 32 | Faulting virtual address (valid with done_o) |

## Verification
The bench builds the walker with its default field widths: ten index bits per level and a twelve-bit offset. With these widths a sparse memory model of a few entries places walks at both ends of each index range (0 and 1023) and at an all-ones offset. The memory model's response latency is set per scenario, from one to five cycles, so the wait states are held for different lengths. A request held high during a walk tests whether the busy controller ignores it.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int ENTRY_OK_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_WAIT_DIR,
        ST_READ_PTE,
        ST_WAIT_PTE,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/pw_addr_split.sv
module pw_addr_split #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int AW = 2 * IDX_W + OFF_W
) (
    input  logic [AW-1:0]    va_i,
    output logic [IDX_W-1:0] top_idx_o,
    output logic [IDX_W-1:0] sub_idx_o,
    output logic [OFF_W-1:0] off_o
);
    assign top_idx_o = va_i[AW-1 -: IDX_W];
    assign sub_idx_o = va_i[OFF_W +: IDX_W];
    assign off_o     = va_i[OFF_W-1:0];
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int AW = 2 * IDX_W + OFF_W,
    localparam int PN_W = AW - OFF_W
) (
    input  logic [PN_W-1:0]  page_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [AW-1:0]    addr_o
);
    logic [AW-1:0] base_w;
    logic [AW-1:0] step_w;

    assign base_w = {page_i, {OFF_W{1'b0}}};
    assign step_w = {{(AW-IDX_W-2){1'b0}}, idx_i, 2'b00};
    assign addr_o = base_w + step_w;
endmodule

// File: rtl/pw_entry_dec.sv
module pw_entry_dec #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int AW = 2 * IDX_W + OFF_W,
    localparam int PN_W = AW - OFF_W
) (
    input  logic [AW-1:0]   entry_i,
    output logic            ok_o,
    output logic [PN_W-1:0] page_o
);
    logic unused_flags;

    assign ok_o         = entry_i[pw_pkg::ENTRY_OK_BIT];
    assign page_o       = entry_i[AW-1:OFF_W];
    assign unused_flags = ^entry_i[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int AW = 2 * IDX_W + OFF_W,
    localparam int PN_W = AW - OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] dir_base_i,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic [AW-1:0] req_va_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_rsp_valid_i,
    input  logic [AW-1:0] mem_rsp_data_i,
    output logic          done_o,
    output logic          fault_o,
    output logic [AW-1:0] pa_o,
    output logic [AW-1:0] fault_va_o
);
    walk_state_e     state_q, state_d;
    logic [AW-1:0]   va_q;
    logic [PN_W-1:0] tbl_page_q;
    logic [AW-1:0]   pa_q;
    logic            fault_q;

    logic [IDX_W-1:0] top_idx, sub_idx;
    logic [OFF_W-1:0] va_off;
    logic [AW-1:0]    dir_addr, pte_addr;
    logic             ent_ok;
    logic [PN_W-1:0]  ent_page;
    logic             unused_base;

    assign unused_base = ^dir_base_i[OFF_W-1:0];

    pw_addr_split #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .va_i(va_q), .top_idx_o(top_idx), .sub_idx_o(sub_idx), .off_o(va_off)
    );

    pw_entry_addr #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_dir_addr (
        .page_i(dir_base_i[AW-1:OFF_W]), .idx_i(top_idx), .addr_o(dir_addr)
    );

    pw_entry_addr #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_pte_addr (
        .page_i(tbl_page_q), .idx_i(sub_idx), .addr_o(pte_addr)
    );

    pw_entry_dec #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_dec (
        .entry_i(mem_rsp_data_i), .ok_o(ent_ok), .page_o(ent_page)
    );

    // State register and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            tbl_page_q <= '0;
            pa_q       <= '0;
            fault_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid_i) begin
                va_q    <= req_va_i;
                pa_q    <= '0;
                fault_q <= 1'b0;
            end
            if (state_q == ST_WAIT_DIR && mem_rsp_valid_i) begin
                tbl_page_q <= ent_page;
                if (!ent_ok) fault_q <= 1'b1;
            end
            if (state_q == ST_WAIT_PTE && mem_rsp_valid_i) begin
                if (ent_ok) pa_q    <= {ent_page, va_off};
                else        fault_q <= 1'b1;
            end
        end
    end

    // Next state and memory port
    always_comb begin
        state_d    = state_q;
        mem_req_o  = 1'b0;
        mem_addr_o = '0;
        unique case (state_q)
            ST_IDLE:     if (req_valid_i) state_d = ST_READ_DIR;
            ST_READ_DIR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = dir_addr;
                state_d    = ST_WAIT_DIR;
            end
            ST_WAIT_DIR: if (mem_rsp_valid_i) state_d = ent_ok ? ST_READ_PTE : ST_DONE;
            ST_READ_PTE: begin
                mem_req_o  = 1'b1;
                mem_addr_o = pte_addr;
                state_d    = ST_WAIT_PTE;
            end
            ST_WAIT_PTE: if (mem_rsp_valid_i) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign req_ready_o = (state_q == ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign fault_o     = fault_q;
    assign pa_o        = pa_q;
    assign fault_va_o  = fault_q ? va_q : '0;

    // R10
    mem_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready_o));

    // R4
    dir_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DIR && mem_rsp_valid_i && !mem_rsp_data_i[ENTRY_OK_BIT])
        |=> (done_o && fault_o && !mem_req_o));

    // R3
    pte_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && state_q == ST_READ_PTE) |-> ($past(state_q) == ST_WAIT_DIR));

    // R6
    pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> (pa_o[OFF_W-1:0] == va_q[OFF_W-1:0]));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready_o && req_valid_i) |=> $stable(va_q));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    localparam logic [31:0] DIR_BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready, mem_req, done, fault;
    logic [31:0] mem_addr, pa, fault_va;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    logic [31:0] mem [logic [31:0]];
    int          lat = 1;
    int          reads = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] paddr = '0;
    logic [31:0] a_prev = '0, a_last = '0;

    int total = 0, fails = 0;

    always #10 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .dir_base_i(DIR_BASE | 32'h0000_0ABC),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
        .done_o(done), .fault_o(fault), .pa_o(pa), .fault_va_o(fault_va)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (mem_req) begin
            pend   <= 1'b1;
            cnt    <= lat;
            paddr  <= mem_addr;
            reads  <= reads + 1;
            a_prev <= a_last;
            a_last <= mem_addr;
        end else if (pend) begin
            if (cnt <= 1) begin
                pend      <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_data  <= rd(paddr);
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkva(input int t, input int s, input int o);
        return {t[9:0], s[9:0], o[11:0]};
    endfunction

    task automatic walk(input logic [31:0] va, input int l, output logic f,
                        output logic [31:0] p, output logic [31:0] fv, output int n);
        int r0, c;
        lat = l;
        r0  = reads;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        c = 0;
        while (!done && c < 60) begin
            @(negedge clk);
            c++;
        end
        chk("R7 done seen", {31'b0, done}, 32'h1);
        f  = fault;
        p  = pa;
        fv = fault_va;
        @(negedge clk);
        chk("R7 done one cycle", {31'b0, done}, 32'h0);
        n = reads - r0;
    endtask

    task automatic t_reset;
        chk("R9 ready", {31'b0, req_ready}, 32'h1);
        chk("R9 done", {31'b0, done}, 32'h0);
        chk("R9 mem_req", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_success;
        logic f; logic [31:0] p, fv; int n;
        walk(mkva(3, 5, 12'h1A4), 1, f, p, fv, n);
        chk("R6 fault low", {31'b0, f}, 32'h0);
        chk("R6 pa", p, 32'h000A_B1A4);
        chk("R7 fault_va zero", fv, 32'h0);
        chk("R2 dir addr", a_prev, DIR_BASE + 32'd12);
        chk("R3 pte addr", a_last, 32'h0002_0014);
        chk("R1 two reads", n, 32'd2);
    endtask

    task automatic t_dir_fault;
        logic f; logic [31:0] p, fv; int n;
        walk(mkva(7, 9, 12'h055), 3, f, p, fv, n);
        chk("R4 fault", {31'b0, f}, 32'h1);
        chk("R4 one read", n, 32'd1);
        chk("R2 dir addr", a_last, DIR_BASE + 32'd28);
        chk("R7 fault_va", fv, mkva(7, 9, 12'h055));
        chk("R7 pa zero", p, 32'h0);
        walk(mkva(200, 1, 0), 2, f, p, fv, n);
        chk("R4 unmapped fault", {31'b0, f}, 32'h1);
        chk("R4 unmapped one read", n, 32'd1);
    endtask

    task automatic t_pte_fault;
        logic f; logic [31:0] p, fv; int n;
        walk(mkva(3, 6, 12'h800), 5, f, p, fv, n);
        chk("R5 fault", {31'b0, f}, 32'h1);
        chk("R5 two reads", n, 32'd2);
        chk("R3 pte addr", a_last, 32'h0002_0018);
        chk("R7 fault_va", fv, mkva(3, 6, 12'h800));
    endtask

    task automatic t_edges;
        logic f; logic [31:0] p, fv; int n;
        walk(mkva(1023, 1023, 12'hFFF), 4, f, p, fv, n);
        chk("R1 top edge pa", p, 32'hFFFF_FFFF);
        chk("R2 top edge dir addr", a_prev, DIR_BASE + 32'd4092);
        chk("R3 top edge pte addr", a_last, 32'h0004_0FFC);
        chk("R6 top edge fault", {31'b0, f}, 32'h0);
        walk(mkva(0, 0, 0), 1, f, p, fv, n);
        chk("R1 low edge pa", p, 32'h1234_5000);
        chk("R2 low edge dir addr", a_prev, DIR_BASE);
        chk("R3 low edge pte addr", a_last, 32'h0005_0000);
    endtask

    task automatic t_busy;
        int r0, c;
        lat = 2;
        r0  = reads;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = mkva(3, 5, 12'h00C);
        @(negedge clk);
        req_va = mkva(7, 0, 0);
        chk("R8 ready low busy", {31'b0, req_ready}, 32'h0);
        c = 0;
        while (!done && c < 60) begin
            @(negedge clk);
            c++;
        end
        req_valid = 1'b0;
        chk("R8 result of first", pa, 32'h000A_B00C);
        chk("R8 no fault from ignored", {31'b0, fault}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R8 no extra walk", reads - r0, 32'd2);
        chk("R8 ready again", {31'b0, req_ready}, 32'h1);
    endtask

    initial begin
        mem[DIR_BASE + 32'd12]   = 32'h0002_0001;
        mem[32'h0002_0014]       = 32'h000A_BFFF;
        mem[32'h0002_0018]       = 32'h000C_DFFE;
        mem[DIR_BASE + 32'd28]   = 32'h0003_0FFE;
        mem[DIR_BASE + 32'd4092] = 32'h0004_0FFF;
        mem[32'h0004_0FFC]       = 32'hFFFF_F001;
        mem[DIR_BASE]            = 32'h0005_0001;
        mem[32'h0005_0000]       = 32'h1234_5001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_success();
        t_dir_fault();
        t_pte_fault();
        t_edges();
        t_busy();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule